// File: doc/BRIEF.md
# Write Issue and Re-issue Controller

This block paces a stream of write requests from a bus master onto a shared system bus that is gated by a write-ready handshake. A pending write sits at the head of an upstream queue. The controller drives it onto the bus for one cycle. In that drive cycle it decides whether the far side accepted it, using the present value of write-ready and the value it held two cycles earlier. An accepted write is popped from the queue. A refused write is driven again, unchanged, after a one-cycle gap. Because every drive cycle is followed by a gap cycle, at most one write goes out every two cycles.

A static mode input picks between two behaviours. In re-issue mode both write-ready samples must be high for a write to count. Pipelined mode adds an allowance: when write-ready has just fallen, one more write may count on the strength of the two-cycles-earlier sample alone. The allowance is then spent. It comes back only after write-ready has been seen high on two consecutive cycles. The upstream queue must hold its head stable until it is popped. The mode input is meant to change only while the bus is idle.

Top module: `wr_issue_ctrl`

## Requirements
- R1: `valid_out` is never high on two consecutive cycles. With a request pending and write-ready held high, drives fall on every second cycle and every drive after the first is popped.
- R2: `req_pop` is high only in a drive cycle in which `wr_ready` was sampled high two cycles earlier. Outside the R4 allowance, `wr_ready` must also be high in that same cycle.
- R3: `out_cmd` is 2'b00 when no write is driven, 2'b01 on the first drive of a write, and 2'b10 on a repeat. A repeat carries the same address and data as the refused drive and follows it after exactly one gap cycle.
- R4: In pipelined mode (`mode_pipe`=1), a drive is popped when `wr_ready` is low in the drive cycle but was high two cycles earlier, provided the allowance is unspent.
- R5: Once the R4 allowance is spent, no further drive is popped with `wr_ready` low until `wr_ready` has been high on two consecutive cycles.
- R6: In re-issue mode (`mode_pipe`=0), a drive with `wr_ready` low is never popped.
- R7: While `rst_n` is low, `valid_out`, `out_cmd` and `req_pop` are 0, taking effect at once without a clock. The internal release follows two clock edges after `rst_n` rises.
- R8: With `req_valid` low and no refused write outstanding, nothing is driven, and `req_pop` stays low.
- R9: A new drive carries the address and data at the queue head in the gap cycle before it. After a pop, the next drive carries the next head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pipe | input | 1 | 0: re-issue mode, 1: pipelined mode |
| req_valid | input | 1 | Queue head holds a pending write |
| req_addr | input | ADDR_W | Address of the queue head |
| req_data | input | DATA_W | Data of the queue head |
| req_pop | output | 1 | The current drive counts as issued; remove the head |
| wr_ready | input | 1 | Write-ready from the receiving side, active high |
| valid_out | output | 1 | A write is being driven on the bus this cycle |
| out_addr | output | ADDR_W | Address being driven |
| out_data | output | DATA_W | Data being driven |
| out_cmd | output | 2 | Command code: none, first drive, repeat |

## Verification
The bench drives write-ready patterns in which the present and two-cycles-earlier samples disagree in both directions. A controller that looked at only one of the two samples would pop a write the receiver never agreed to, or would hold a write back. In pipelined mode it spends the allowance and then offers a second lone high pulse on write-ready. A design that refilled the allowance on a single high sample would take that second extra write, which the rules forbid. Other runs hold write-ready low for a long stretch and compare every repeat against the first drive, count drives and pops under continuous ready to catch a broken two-cycle cadence, and assert reset in the middle of a drive to show the outputs clear without a clock.

// File: rtl/wr_issue_pkg.sv
`timescale 1ns/1ps
package wr_issue_pkg;
  // Command code on out_cmd
  typedef enum logic [1:0] {
    WCMD_NONE  = 2'b00,
    WCMD_FIRST = 2'b01,
    WCMD_RETRY = 2'b10
  } wcmd_e;
endpackage

// File: rtl/wr_issue_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of the core reset.
module wr_issue_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/wr_issue_rdy_hist.sv
`timescale 1ns/1ps
// Shift register of past write-ready samples; hist[k] is the value k+1 cycles ago.
module wr_issue_rdy_hist #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy_in,
  output logic [DEPTH-1:0] hist
);
  logic [DEPTH-1:0] hist_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign hist_d[i] = rdy_in;
      end else begin : g_tail
        assign hist_d[i] = hist[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_d;
  end
endmodule

// File: rtl/wr_issue_judge.sv
`timescale 1ns/1ps
// Combinational decision taken in a drive cycle.
module wr_issue_judge #(
  parameter int DEPTH = 2
) (
  input  logic             drive,
  input  logic             mode_pipe,
  input  logic             rdy_now,
  input  logic [DEPTH-1:0] hist,
  input  logic             extra_used,
  output logic             issued,
  output logic             take_extra,
  output logic             refill
);
  logic rdy_lag;
  logic ok_norm;

  always_comb begin
    rdy_lag    = hist[DEPTH-1];
    ok_norm    = drive && rdy_lag && rdy_now;
    take_extra = drive && mode_pipe && rdy_lag && !rdy_now && !extra_used;
    issued     = ok_norm || take_extra;
    // allowance comes back after two consecutive high samples
    refill     = rdy_now && hist[0];
  end
endmodule

// File: rtl/wr_issue_token.sv
`timescale 1ns/1ps
// Tracks whether the pipelined-mode extra write has been spent.
module wr_issue_token (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pipe,
  input  logic take_extra,
  input  logic refill,
  output logic extra_used
);
  logic extra_d;
  logic extra_en;

  always_comb begin
    extra_d = extra_used;
    if (!mode_pipe)      extra_d = 1'b0;
    else if (take_extra) extra_d = 1'b1;
    else if (refill)     extra_d = 1'b0;
    extra_en = (extra_d != extra_used);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        extra_used <= 1'b0;
    else if (extra_en) extra_used <= extra_d;
  end
endmodule

// File: rtl/wr_issue_launch.sv
`timescale 1ns/1ps
// Drive register: loads the queue head, enforces the gap, keeps refused writes.
module wr_issue_launch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              issued,
  output logic              drive_q,
  output logic              retry_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic drive_d;
  logic retry_d;
  logic load_en;
  logic retry_en;

  always_comb begin
    drive_d  = !drive_q && (req_valid || retry_q);
    load_en  = drive_d && !retry_q;
    retry_en = drive_q;
    retry_d  = !issued;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      drive_q <= drive_d;
      if (retry_en) retry_q <= retry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end
endmodule

// File: rtl/wr_issue_ctrl.sv
`timescale 1ns/1ps
module wr_issue_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int RDY_LAG     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_pop,
  input  logic              wr_ready,
  output logic              valid_out,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_cmd
);
  import wr_issue_pkg::*;

  logic               rst_n_core;
  logic [RDY_LAG-1:0] rdy_hist;
  logic               drive_q;
  logic               retry_q;
  logic               extra_used;
  logic               issued;
  logic               take_extra;
  logic               refill;
  wcmd_e              cmd;

  wr_issue_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_core)
  );

  wr_issue_rdy_hist #(.DEPTH(RDY_LAG)) u_hist (
    .clk(clk), .rst_n(rst_n_core), .rdy_in(wr_ready), .hist(rdy_hist)
  );

  wr_issue_judge #(.DEPTH(RDY_LAG)) u_judge (
    .drive(drive_q), .mode_pipe(mode_pipe), .rdy_now(wr_ready),
    .hist(rdy_hist), .extra_used(extra_used),
    .issued(issued), .take_extra(take_extra), .refill(refill)
  );

  wr_issue_token u_token (
    .clk(clk), .rst_n(rst_n_core), .mode_pipe(mode_pipe),
    .take_extra(take_extra), .refill(refill), .extra_used(extra_used)
  );

  wr_issue_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
    .clk(clk), .rst_n(rst_n_core), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .issued(issued),
    .drive_q(drive_q), .retry_q(retry_q), .addr_q(out_addr), .data_q(out_data)
  );

  always_comb begin
    if (!drive_q)     cmd = WCMD_NONE;
    else if (retry_q) cmd = WCMD_RETRY;
    else              cmd = WCMD_FIRST;
  end

  assign out_cmd   = cmd;
  assign valid_out = drive_q;
  assign req_pop   = issued;
endmodule

// File: rtl/wr_issue_chk.sv
`timescale 1ns/1ps
module wr_issue_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_pipe,
  input logic              wr_ready,
  input logic              valid_out,
  input logic              req_pop,
  input logic [1:0]        out_cmd,
  input logic [ADDR_W-1:0] out_addr
);
  logic              seen1;
  logic              seen2;
  logic              extra_taken;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1       <= 1'b0;
      seen2       <= 1'b0;
      extra_taken <= 1'b0;
      last_addr   <= '0;
    end else begin
      seen1 <= wr_ready;
      seen2 <= seen1;
      if (valid_out) last_addr <= out_addr;
      if (req_pop && !wr_ready)   extra_taken <= 1'b1;
      else if (wr_ready && seen1) extra_taken <= 1'b0;
    end
  end

  assert_gap_after_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);

  assert_pop_needs_lag_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> (valid_out && seen2));

  assert_repeat_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && out_cmd == 2'b10) |-> (out_addr == last_addr));

  assert_idle_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (out_cmd == 2'b00));

  assert_single_extra_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop && !wr_ready) |-> !extra_taken);

  assert_reissue_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop && !mode_pipe) |-> wr_ready);

  assert_pop_only_in_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> valid_out);
endmodule

bind wr_issue_ctrl wr_issue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .wr_ready(wr_ready),
  .valid_out(valid_out), .req_pop(req_pop), .out_cmd(out_cmd),
  .out_addr(out_addr)
);

// File: tb/tb_wr_issue_ctrl.sv
`timescale 1ns/1ps
module tb_wr_issue_ctrl;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [AW-1:0] ABASE = 32'h0000_0100;
  localparam logic [DW-1:0] DBASE = 64'hA5A5_0000_0000_5000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_pipe;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_pop;
  logic          wr_ready;
  logic          valid_out;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [1:0]    out_cmd;

  int checks = 0;
  int errors = 0;
  int idx    = 0;
  logic          s_valid, s_pop;
  logic [1:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;

  always #5 clk = ~clk;

  wr_issue_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .req_pop(req_pop),
    .wr_ready(wr_ready), .valid_out(valid_out), .out_addr(out_addr),
    .out_data(out_data), .out_cmd(out_cmd)
  );

  // {rst, mode, req_valid, wr_ready, exp_valid, exp_cmd[1:0], exp_pop, exp_idx[3:0]}
  localparam int NV = 38;
  localparam logic [11:0] VEC [NV] = '{
    // re-issue mode
    12'b1_0_1_1_0_00_0_0000, 12'b0_0_1_1_1_01_0_0000, // R2 lag sample low
    12'b0_0_1_1_0_00_0_0000, 12'b0_0_1_1_1_10_1_0000, // R3 repeat popped
    12'b0_0_1_1_0_00_0_0000, 12'b0_0_1_1_1_01_1_0001, // R9 next head
    12'b0_0_1_1_0_00_0_0000, 12'b0_0_1_0_1_01_0_0010, // R6 ready low now
    12'b0_0_1_1_0_00_0_0000, 12'b0_0_1_1_1_10_0_0010, // R2 lag low
    12'b0_0_1_1_0_00_0_0000, 12'b0_0_1_1_1_10_1_0010,
    12'b0_0_0_1_0_00_0_0000, 12'b0_0_0_1_0_00_0_0000, // R8 idle
    // pipelined mode
    12'b1_1_1_1_0_00_0_0000, 12'b0_1_1_1_1_01_0_0000,
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_1_1_10_1_0000,
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_0_1_01_1_0001, // R4 extra write
    12'b0_1_1_0_0_00_0_0000, 12'b0_1_1_1_1_01_0_0010,
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_1_1_10_1_0010, // refilled
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_0_1_01_1_0011, // R4 extra again
    12'b0_1_1_0_0_00_0_0000, 12'b0_1_1_1_1_01_0_0100,
    12'b0_1_1_0_0_00_0_0000, 12'b0_1_1_0_1_10_0_0100, // R5 spent
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_1_1_10_0_0100,
    12'b0_1_1_1_0_00_0_0000, 12'b0_1_1_1_1_10_1_0100,
    12'b0_1_1_0_0_00_0_0000, 12'b0_1_1_0_1_01_1_0101, // R5 refilled
    12'b0_1_0_1_0_00_0_0000, 12'b0_1_0_1_0_00_0_0000  // R8 idle
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_pipe = m; req_valid = 1'b0; wr_ready = 1'b0;
    idx = 0; req_addr = ABASE; req_data = DBASE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic cyc(input logic m, input logic rv, input logic rdy);
    @(negedge clk);
    mode_pipe = m; req_valid = rv; wr_ready = rdy;
    req_addr = ABASE + AW'(idx);
    req_data = DBASE + DW'(idx);
    #4;
    s_valid = valid_out; s_pop = req_pop; s_cmd = out_cmd;
    s_addr = out_addr;   s_data = out_data;
    @(posedge clk);
    if (s_pop) idx++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int drives;
    int pops;
    do_reset(1'b0);
    // R7 reset state
    #1;
    chk("R7 valid after reset", 64'(valid_out), 64'd0);
    chk("R7 cmd after reset", 64'(out_cmd), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      if (v[11]) do_reset(v[10]);
      cyc(v[10], v[9], v[8]);
      chk($sformatf("R1/R8 valid row %0d", i), 64'(s_valid), 64'(v[7]));
      chk($sformatf("R3 cmd row %0d", i), 64'(s_cmd), 64'(v[6:5]));
      chk($sformatf("R2/R4/R5/R6 pop row %0d", i), 64'(s_pop), 64'(v[4]));
      if (v[7]) begin
        chk($sformatf("R9 addr row %0d", i), 64'(s_addr), 64'(ABASE + AW'(v[3:0])));
        chk($sformatf("R9 data row %0d", i), s_data, DBASE + DW'(v[3:0]));
      end
    end

    // R3/R6: ready held low in re-issue mode, same write repeats unpopped
    do_reset(1'b0);
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      chk("R6 no pop with ready low", 64'(s_pop), 64'd0);
      if (i % 2 == 1) begin
        chk("R3 repeat cmd", 64'(s_cmd), (i == 1) ? 64'd1 : 64'd2);
        chk("R3 repeat addr", 64'(s_addr), 64'(ABASE));
        chk("R3 repeat data", s_data, DBASE);
      end else begin
        chk("R1 gap cycle", 64'(s_valid), 64'd0);
      end
    end

    // R1: continuous ready, one write per two cycles
    do_reset(1'b1);
    drives = 0; pops = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b1, 1'b1);
      if (s_valid) drives++;
      if (s_pop) pops++;
    end
    chk("R1 drive count", 64'(drives), 64'd10);
    chk("R1 pop count", 64'(pops), 64'd9);

    // R7: asynchronous reset in the middle of a drive
    @(negedge clk);
    mode_pipe = 1'b1; req_valid = 1'b1; wr_ready = 1'b1;
    if (!valid_out) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 async valid", 64'(valid_out), 64'd0);
    chk("R7 async cmd", 64'(out_cmd), 64'd0);
    chk("R7 async pop", 64'(req_pop), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule